// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This datapath block replicates a scalar, or a short tuple of elements, taken from a source operand across every element of a destination vector up to 512 bits wide. Element widths of 8, 16, 32 and 64 bits are supported. The active vector length is 128, 256 or 512 bits. A tuple of T elements repeats with period T, so destination element j takes source element j mod T.

Each destination element is gated by a per-element write mask. A masked-off element either keeps its old value (merge) or is cleared (zero). A legacy unmasked form ignores the mask entirely. Destination bits above the active vector length are always cleared. The block also classifies the mode fields and raises an illegal flag for reserved shape, length and source combinations; in that case the old destination passes through unchanged. Results and flags are registered one cycle after a start strobe.

Top module: `vbcast_unit`

## Requirements
- R1: Field codes: `ew_i` 0/1/2/3 = 8/16/32/64-bit elements; `vl_i` 0/1/2 = 128/256/512 bits, and 3 is reserved; `tup_i` is log2 of the tuple length T. With T=1, every live element equals source bits [W-1:0], where W is the element width.
- R2: With a tuple, destination element j equals source element (j mod T). The legal tuples are 2, 4 and 8 elements of 32 bits, and 2 and 4 elements of 64 bits.
- R3: When masking is on and merge mode is chosen (`zero_mask_i`=0), an element whose bit `mask_i[j]` is 0 keeps its value from `dst_old_i`.
- R4: When masking is on and zero mode is chosen (`zero_mask_i`=1), an element whose mask bit is 0 reads zero.
- R5: The mask has no effect when `mask_en_i`=0 or `legacy_i`=1. Mask bits at or above the element count never affect the result.
- R6: Destination bits from the active vector length up to bit 511 are zero on every legal operation.
- R7: The illegal flag is set in each of these cases: `vl_i`=3; a tuple of 8- or 16-bit elements; 8 elements of 64 bits; a 128-bit tuple at a 128-bit length; a 256-bit tuple at any length other than 512; a legacy operation at the 512-bit length; a legacy 64-bit single-element operation at 128 bits; a legacy tuple that is not 128 bits.
- R8: A register source (`src_reg_i`=1) with a tuple of 128 or 256 bits sets the illegal flag. A register source with a smaller tuple is legal.
- R9: A `vvvv_i` value other than 4'b1111 sets the illegal flag.
- R10: When the illegal flag is set, `dst_o` equals `dst_old_i` unchanged.
- R11: `dst_o`, `illegal_o` and a one-cycle `valid_o` pulse appear on the clock edge after the edge that samples `start_i`. Without a start, `dst_o` and `illegal_o` hold their values. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch an operation this cycle |
| src_i | input | 256 | Source scalar or tuple, element 0 at the low bits |
| dst_old_i | input | 512 | Previous destination value |
| mask_i | input | 64 | Per-element write mask, bit j for element j |
| ew_i | input | 2 | Element width code |
| tup_i | input | 2 | log2 of the tuple length |
| vl_i | input | 2 | Vector length code |
| mask_en_i | input | 1 | Apply the write mask |
| zero_mask_i | input | 1 | 1 = zero masking, 0 = merge masking |
| src_reg_i | input | 1 | Source is a register, not memory |
| legacy_i | input | 1 | Legacy unmasked form |
| vvvv_i | input | 4 | Extra register field, must be 4'b1111 |
| dst_o | output | 512 | New destination value |
| valid_o | output | 1 | Result valid strobe |
| illegal_o | output | 1 | Illegal encoding flag |

## Verification
Directed cases come first. A single byte broadcast at full length shows that replication reaches all 64 lanes. Tuples of two, four and eight elements show that the source index wraps at the tuple length rather than at the source width. Alternating masks under merge and zero modes separate old data from cleared lanes. A mask that is set only above the element count shows that the unused mask bits are ignored. Each reserved combination is applied with a known old value, which proves both the flag and the pass-through. Seeded random modes, masks and data are then compared against a byte-wise bench model.

// File: rtl/vbcast_pkg.sv
package vbcast_pkg;
  localparam int unsigned VL_MAX = 512;
  localparam int unsigned SRC_W  = 256;
  localparam int unsigned NBYTE  = VL_MAX / 8;

  typedef enum logic [1:0] {EW_B = 2'd0, EW_H = 2'd1, EW_S = 2'd2, EW_D = 2'd3} ew_e;
  typedef enum logic [1:0] {VL_128 = 2'd0, VL_256 = 2'd1, VL_512 = 2'd2, VL_RSV = 2'd3} vl_e;

  typedef struct packed {
    ew_e        ew;
    logic [1:0] tup_log2;
    vl_e        vl;
    logic       src_reg;
    logic       legacy;
    logic [3:0] vvvv;
  } mode_t;
endpackage

// File: rtl/vbcast_legal.sv
module vbcast_legal
  import vbcast_pkg::*;
(
  input  mode_t mode_i,
  output logic  illegal_o
);
  logic [2:0] tb_log2;  // log2 of tuple bytes
  logic bad_shape, bad_vl, bad_reg, bad_leg, bad_vvvv;

  always_comb begin
    tb_log2   = {1'b0, mode_i.ew} + {1'b0, mode_i.tup_log2};
    bad_shape = (mode_i.tup_log2 != 2'd0 && (mode_i.ew == EW_B || mode_i.ew == EW_H))
             || (mode_i.tup_log2 == 2'd3 && mode_i.ew == EW_D);
    bad_vl    = (mode_i.vl == VL_RSV)
             || (tb_log2 == 3'd4 && mode_i.vl == VL_128)
             || (tb_log2 == 3'd5 && mode_i.vl != VL_512);
    bad_reg   = mode_i.src_reg && (tb_log2 >= 3'd4);
    bad_leg   = mode_i.legacy && ((mode_i.vl == VL_512)
             || (mode_i.tup_log2 == 2'd0 && mode_i.ew == EW_D && mode_i.vl == VL_128)
             || (mode_i.tup_log2 != 2'd0 && tb_log2 != 3'd4));
    bad_vvvv  = (mode_i.vvvv != 4'hF);
    illegal_o = bad_shape | bad_vl | bad_reg | bad_leg | bad_vvvv;
  end
endmodule

// File: rtl/vbcast_replicate.sv
module vbcast_replicate
  import vbcast_pkg::*;
#(
  parameter int unsigned VL_W  = VL_MAX,
  parameter int unsigned SRC_B = SRC_W
) (
  input  logic [SRC_B-1:0] src_i,
  input  ew_e              ew_i,
  input  logic [1:0]       tup_log2_i,
  output logic [VL_W-1:0]  rep_o
);
  localparam int unsigned NW = 4;

  logic [VL_W-1:0] src_ext;
  logic [2:0]      tmask;
  logic [VL_W-1:0] rep_w [NW];

  assign src_ext = {{(VL_W-SRC_B){1'b0}}, src_i};
  assign tmask   = 3'((4'd1 << tup_log2_i) - 4'd1);

  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int unsigned W = 8 << g;
    localparam int unsigned N = VL_W / W;
    logic [VL_W-1:0] rep;
    for (genvar j = 0; j < N; j++) begin : g_lane
      localparam logic [2:0] JL = 3'(j % 8);
      logic [2:0] idx;
      assign idx = JL & tmask;
      assign rep[j*W +: W] = src_ext[32'(idx)*W +: W];
    end
    assign rep_w[g] = rep;
  end

  assign rep_o = rep_w[ew_i];
endmodule

// File: rtl/vbcast_lane_mask.sv
module vbcast_lane_mask
  import vbcast_pkg::*;
#(
  parameter int unsigned NB = NBYTE
) (
  input  logic [NB-1:0] mask_i,
  input  logic          mask_on_i,
  input  ew_e           ew_i,
  input  vl_e           vl_i,
  output logic [NB-1:0] wr_en_o,
  output logic [NB-1:0] live_o
);
  localparam int unsigned AW = $clog2(NB);

  logic [AW+1:0] lim;  // active length in bytes

  always_comb begin
    lim = (AW+2)'(16) << vl_i;
    for (int b = 0; b < NB; b++) begin
      wr_en_o[b] = !mask_on_i || mask_i[AW'(b) >> ew_i];
      live_o[b]  = (AW+2)'(b) < lim;
    end
  end
endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
  import vbcast_pkg::*;
#(
  parameter int unsigned VL_W  = VL_MAX,
  parameter int unsigned SRC_B = SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [SRC_B-1:0]  src_i,
  input  logic [VL_W-1:0]   dst_old_i,
  input  logic [VL_W/8-1:0] mask_i,
  input  logic [1:0]        ew_i,
  input  logic [1:0]        tup_i,
  input  logic [1:0]        vl_i,
  input  logic              mask_en_i,
  input  logic              zero_mask_i,
  input  logic              src_reg_i,
  input  logic              legacy_i,
  input  logic [3:0]        vvvv_i,
  output logic [VL_W-1:0]   dst_o,
  output logic              valid_o,
  output logic              illegal_o
);
  localparam int unsigned NB = VL_W / 8;

  mode_t           mode;
  logic            illegal_d;
  logic [VL_W-1:0] rep, dst_d;
  logic [NB-1:0]   wr_en, live;

  assign mode = '{ew: ew_e'(ew_i), tup_log2: tup_i, vl: vl_e'(vl_i),
                  src_reg: src_reg_i, legacy: legacy_i, vvvv: vvvv_i};

  vbcast_legal u_legal (.mode_i(mode), .illegal_o(illegal_d));

  vbcast_replicate #(.VL_W(VL_W), .SRC_B(SRC_B)) u_rep (
    .src_i(src_i), .ew_i(mode.ew), .tup_log2_i(tup_i), .rep_o(rep)
  );

  vbcast_lane_mask #(.NB(NB)) u_mask (
    .mask_i(mask_i), .mask_on_i(mask_en_i & ~legacy_i), .ew_i(mode.ew),
    .vl_i(mode.vl), .wr_en_o(wr_en), .live_o(live)
  );

  always_comb begin
    for (int b = 0; b < NB; b++) begin
      if (illegal_d)     dst_d[b*8 +: 8] = dst_old_i[b*8 +: 8];
      else if (!live[b]) dst_d[b*8 +: 8] = 8'h00;
      else if (wr_en[b]) dst_d[b*8 +: 8] = rep[b*8 +: 8];
      else if (zero_mask_i) dst_d[b*8 +: 8] = 8'h00;
      else               dst_d[b*8 +: 8] = dst_old_i[b*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_o     <= '0;
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        dst_o     <= dst_d;
        illegal_o <= illegal_d;
      end
    end
  end
endmodule

// File: rtl/vbcast_unit_chk.sv
module vbcast_unit_chk #(
  parameter int unsigned VL_W = 512
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [VL_W-1:0] dst_old_i,
  input logic [1:0]      tup_i,
  input logic [1:0]      vl_i,
  input logic            src_reg_i,
  input logic [3:0]      vvvv_i,
  input logic [VL_W-1:0] dst_o,
  input logic            valid_o,
  input logic            illegal_o
);
  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R11
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o); // R11
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(dst_o) && $stable(illegal_o)); // R11
  AST_ILLEGAL_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!illegal_o || dst_o == $past(dst_old_i))); // R10
  AST_VVVV_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && vvvv_i != 4'hF) |=> illegal_o); // R9
  AST_REG_WIDE_TUPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && src_reg_i && tup_i == 2'd3) |=> illegal_o); // R8
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && vl_i == 2'd0) |=> (illegal_o || dst_o[VL_W-1:128] == '0)); // R6
endmodule

bind vbcast_unit vbcast_unit_chk #(.VL_W(VL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .dst_old_i(dst_old_i),
  .tup_i(tup_i), .vl_i(vl_i), .src_reg_i(src_reg_i), .vvvv_i(vvvv_i),
  .dst_o(dst_o), .valid_o(valid_o), .illegal_o(illegal_o)
);

// File: tb/vbcast_unit_bench.sv
`timescale 1ns/1ps
module vbcast_unit_bench;
  logic         clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [255:0] src = '0;
  logic [511:0] old = '0;
  logic [63:0]  mask = '0;
  logic [1:0]   ew = '0, tup = '0, vl = '0;
  logic         men = 1'b0, zm = 1'b0, sreg = 1'b0, leg = 1'b0;
  logic [3:0]   vv = 4'hF;
  logic [511:0] dst;
  logic         valid, illegal;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vbcast_unit u_vbcast_unit (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .src_i(src), .dst_old_i(old),
    .mask_i(mask), .ew_i(ew), .tup_i(tup), .vl_i(vl), .mask_en_i(men),
    .zero_mask_i(zm), .src_reg_i(sreg), .legacy_i(leg), .vvvv_i(vv),
    .dst_o(dst), .valid_o(valid), .illegal_o(illegal)
  );

  function automatic bit exp_illegal();
    int tbits = (8 << ew) * (1 << tup);
    bit r = 0;
    if (vv != 4'hF) r = 1;
    if (vl == 2'd3) r = 1;
    if (tup != 0 && ew < 2) r = 1;
    if (tup == 3 && ew == 3) r = 1;
    if (tbits == 128 && vl == 0) r = 1;
    if (tbits == 256 && vl != 2) r = 1;
    if (sreg && tbits >= 128) r = 1;
    if (leg && vl == 2) r = 1;
    if (leg && tup == 0 && ew == 3 && vl == 0) r = 1;
    if (leg && tup != 0 && tbits != 128) r = 1;
    return r;
  endfunction

  function automatic logic [511:0] exp_dst();
    logic [511:0] r, s;
    int eb = 1 << ew, t = 1 << tup, live = 16 << vl;
    if (exp_illegal()) return old;
    s = {256'b0, src};
    for (int b = 0; b < 64; b++) begin
      int j = b / eb, k = b % eb;
      bit en = !men || leg || mask[j];
      if (b >= live)  r[b*8 +: 8] = 8'h00;
      else if (en)    r[b*8 +: 8] = s[((j % t) * eb + k) * 8 +: 8];
      else if (zm)    r[b*8 +: 8] = 8'h00;
      else            r[b*8 +: 8] = old[b*8 +: 8];
    end
    return r;
  endfunction

  task automatic run(input string req);
    logic [511:0] ed;
    bit ei;
    ed = exp_dst();
    ei = exp_illegal();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checks++;
    if (dst !== ed || illegal !== ei || valid !== 1'b1) begin
      errors++;
      $display("FAIL %s dst=%h ill=%b v=%b exp dst=%h ill=%b v=1",
               req, dst, illegal, valid, ed, ei);
    end
  endtask

  task automatic setm(input logic [1:0] e, t, l, input logic me, z, sr, lg,
                      input logic [3:0] v);
    ew = e; tup = t; vl = l; men = me; zm = z; sreg = sr; leg = lg; vv = v;
  endtask

  initial begin
    logic [511:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || dst !== '0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R11 reset v=%b dst=%h ill=%b exp 0", valid, dst, illegal);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    old = {16{32'hDEAD_BEEF}};
    src = {224'h0, 32'h1234_56A5};
    setm(2'd0, 2'd0, 2'd2, 0, 0, 0, 0, 4'hF); run("R1 byte x64");
    setm(2'd3, 2'd0, 2'd1, 0, 0, 0, 0, 4'hF); run("R1 qword vl256");
    src = {64'h4444_4444_4444_4444, 64'h3333_3333_3333_3333,
           64'h2222_2222_2222_2222, 64'h1111_1111_1111_1111};
    setm(2'd2, 2'd1, 2'd1, 0, 0, 0, 0, 4'hF); run("R2 2x32");
    setm(2'd3, 2'd1, 2'd2, 0, 0, 0, 0, 4'hF); run("R2 2x64");
    setm(2'd2, 2'd3, 2'd2, 0, 0, 0, 0, 4'hF); run("R2 8x32");
    setm(2'd3, 2'd2, 2'd2, 0, 0, 0, 0, 4'hF); run("R2 4x64");
    mask = 64'h5555;
    setm(2'd1, 2'd0, 2'd1, 1, 0, 0, 0, 4'hF); run("R3 merge");
    setm(2'd1, 2'd0, 2'd1, 1, 1, 0, 0, 4'hF); run("R4 zero");
    mask = 64'h0;
    setm(2'd2, 2'd0, 2'd1, 1, 1, 0, 1, 4'hF); run("R5 legacy ignores mask");
    setm(2'd0, 2'd0, 2'd2, 0, 1, 0, 0, 4'hF); run("R5 mask off");
    mask = 64'hFFFF_FFFF_FFFF_FFFC;
    setm(2'd3, 2'd0, 2'd0, 1, 0, 0, 0, 4'hF); run("R5 high mask bits ignored");
    old = '1;
    setm(2'd0, 2'd0, 2'd0, 0, 0, 0, 0, 4'hF); run("R6 upper zero vl128");
    setm(2'd2, 2'd2, 2'd0, 0, 0, 0, 0, 4'hF); run("R7 R10 128-bit tuple at 128");
    setm(2'd3, 2'd2, 2'd1, 0, 0, 0, 0, 4'hF); run("R7 R10 256-bit tuple at 256");
    setm(2'd3, 2'd0, 2'd0, 0, 0, 0, 1, 4'hF); run("R7 legacy qword at 128");
    setm(2'd1, 2'd1, 2'd2, 0, 0, 0, 0, 4'hF); run("R7 tuple of halfwords");
    setm(2'd0, 2'd0, 2'd3, 0, 0, 0, 0, 4'hF); run("R7 reserved length");
    setm(2'd2, 2'd2, 2'd1, 0, 0, 1, 0, 4'hF); run("R8 reg source 4x32");
    setm(2'd2, 2'd1, 2'd1, 0, 0, 1, 0, 4'hF); run("R8 reg source 2x32 legal");
    setm(2'd2, 2'd0, 2'd2, 0, 0, 0, 0, 4'hE); run("R9 vvvv");

    held = dst;
    repeat (2) @(negedge clk);
    checks++;
    if (valid !== 1'b0 || dst !== held) begin
      errors++;
      $display("FAIL R11 idle v=%b dst=%h exp v=0 dst=%h", valid, dst, held);
    end

    for (int n = 0; n < 600; n++) begin
      for (int w = 0; w < 8; w++) src[w*32 +: 32] = $urandom;
      for (int w = 0; w < 16; w++) old[w*32 +: 32] = $urandom;
      mask = {$urandom, $urandom};
      setm(2'($urandom), 2'($urandom), 2'($urandom % 3 + (($urandom % 16) == 0 ? 1 : 0)),
           1'($urandom), 1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 10) == 0 ? 4'($urandom) : 4'hF);
      run("R1 R2 R3 R4 R5 R6 R7 R8 R10 random");
      if ($urandom % 4 == 0) @(negedge clk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule